// File: doc/BRIEF.md
# Block Address Translation Matcher

This block translates an effective address through a small set of block-mapping entries. It holds two banks of entries: one serves instruction fetches and one serves data accesses. Each entry maps an aligned region of the effective address space onto a physical region. The region is given by a stored effective base and a base mask. The physical region is given by a physical base. Two enable bits say whether the entry applies in supervisor mode, in user mode, or in both. A two-bit protection code grants no access, read-only access or read/write access.

Software loads entries one at a time through a register-write port. The write takes effect at the next rising clock edge. Lookups are purely combinational. The lookup searches the selected bank from the lowest index upward. An entry whose region matches the address but whose protection refuses the access is passed over, and the search goes on to the next entry. The first entry that accepts the access supplies the physical address and the permissions. When no entry accepts the access, the block reports a miss and every result output is zero.

Top module: `bat_matcher`

## Requirements
- R1: `lk_data` = 1 searches the data bank and `lk_data` = 0 searches the instruction bank. An entry written with `wr_bank` = 1 lives in the data bank, and one written with `wr_bank` = 0 lives in the instruction bank. A write to one bank never changes lookups in the other bank.
- R2: When `lk_user` = 1, only entries with their user-enable bit set are considered. When `lk_user` = 0, only entries with their supervisor-enable bit set are considered.
- R3: An entry's region matches when (`lk_addr` AND mask) equals the stored effective base.
- R4: On a hit, `phys_addr` equals the entry's physical base OR (`lk_addr` AND NOT mask).
- R5: The protection code sets the permissions: 0 grants nothing, 1 grants read only, and 2 or 3 grant read and write. On a hit, `can_read` is 1, `can_write` is 1 exactly for codes 2 and 3, and `can_exec` is 1.
- R6: A matching entry with code 0 is skipped. A matching entry with code 1 is skipped when `lk_write` = 1. In both cases the search continues with the next higher index.
- R7: Among the entries that accept the access, the one with the lowest index is used.
- R8: When no entry accepts the access, `hit`, `can_read`, `can_write` and `can_exec` are 0 and `phys_addr` is 0.
- R9: Reset clears both enable bits of every entry, so no lookup hits. A write with `wr_en` = 1 replaces entry `wr_idx` of bank `wr_bank` at the rising clock edge, and the new entry is used by lookups from then on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Entry write strobe |
| wr_bank | input | 1 | Target bank: 1 data, 0 instruction |
| wr_idx | input | 3 | Target entry index |
| wr_base | input | 32 | Effective base to store |
| wr_mask | input | 32 | Base mask to store |
| wr_phys | input | 32 | Physical base to store |
| wr_sup_en | input | 1 | Entry usable in supervisor mode |
| wr_usr_en | input | 1 | Entry usable in user mode |
| wr_prot | input | 2 | Protection code |
| lk_addr | input | 32 | Effective address to translate |
| lk_data | input | 1 | 1 data access, 0 instruction fetch |
| lk_user | input | 1 | 1 user mode, 0 supervisor mode |
| lk_write | input | 1 | Access is a store |
| hit | output | 1 | An entry accepted the access |
| phys_addr | output | 32 | Translated physical address |
| can_read | output | 1 | Read permitted |
| can_write | output | 1 | Write permitted |
| can_exec | output | 1 | Execute permitted |

## Verification
The assertions assume that software stores an effective base with no bits outside its mask, and a physical base with no bits inside the inverted mask. Without this, the pass-through bits of the physical address could differ from the address. The bench only builds entries that keep this rule: it takes each mask from a set of contiguous high-bit masks and ANDs each random base with that mask. It then picks lookup addresses near stored bases, so that overlapping regions, skipped entries and privilege filtering all occur often.

// File: rtl/bat_matcher.sv
module bat_matcher #(
  parameter int N  = 8,
  parameter int AW = 32,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_bank,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_base,
  input  logic [AW-1:0] wr_mask,
  input  logic [AW-1:0] wr_phys,
  input  logic          wr_sup_en,
  input  logic          wr_usr_en,
  input  logic [1:0]    wr_prot,
  input  logic [AW-1:0] lk_addr,
  input  logic          lk_data,
  input  logic          lk_user,
  input  logic          lk_write,
  output logic          hit,
  output logic [AW-1:0] phys_addr,
  output logic          can_read,
  output logic          can_write,
  output logic          can_exec
);

  logic [AW-1:0] base_q [2][N];
  logic [AW-1:0] mask_q [2][N];
  logic [AW-1:0] phys_q [2][N];
  logic          sup_q  [2][N];
  logic          usr_q  [2][N];
  logic [1:0]    prot_q [2][N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < N; i++) begin
          sup_q[b][i]  <= 1'b0;
          usr_q[b][i]  <= 1'b0;
          prot_q[b][i] <= 2'd0;
          base_q[b][i] <= '0;
          mask_q[b][i] <= '0;
          phys_q[b][i] <= '0;
        end
    end else if (wr_en) begin
      base_q[wr_bank][wr_idx] <= wr_base;
      mask_q[wr_bank][wr_idx] <= wr_mask;
      phys_q[wr_bank][wr_idx] <= wr_phys;
      sup_q[wr_bank][wr_idx]  <= wr_sup_en;
      usr_q[wr_bank][wr_idx]  <= wr_usr_en;
      prot_q[wr_bank][wr_idx] <= wr_prot;
    end
  end

  logic [N-1:0] accept;
  logic [N-1:0] rw_ok;

  for (genvar i = 0; i < N; i++) begin : g_ent
    wire enabled = lk_user ? usr_q[lk_data][i] : sup_q[lk_data][i];
    wire match   = (lk_addr & mask_q[lk_data][i]) == base_q[lk_data][i];
    assign rw_ok[i]  = prot_q[lk_data][i][1];
    assign accept[i] = enabled && match && (prot_q[lk_data][i] != 2'd0)
                       && (!lk_write || rw_ok[i]);
  end

  logic [IW-1:0] sel;
  logic [AW-1:0] sel_mask;

  always_comb begin
    sel = '0;
    for (int i = N - 1; i >= 0; i--)
      if (accept[i]) sel = IW'(i);
  end

  assign sel_mask  = mask_q[lk_data][sel];
  assign hit       = |accept;
  assign phys_addr = hit ? (phys_q[lk_data][sel] | (lk_addr & ~sel_mask)) : '0;
  assign can_read  = hit;
  assign can_write = hit && rw_ok[sel];
  assign can_exec  = hit;

  p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (phys_addr == '0 && !can_read && !can_write && !can_exec));

  p_store_needs_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && lk_write) |-> can_write);

  p_exec_on_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (can_exec && can_read));

  p_low_bits_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((phys_addr & ~sel_mask) == (lk_addr & ~sel_mask)));

  p_lowest_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((accept & ((N'(1) << sel) - N'(1))) == '0));

  p_reset_empty_r9: assert property (@(posedge clk)
    $past(!rst_n) |-> !hit);

endmodule

// File: tb/bat_matcher_test.sv
module bat_matcher_test;
  localparam int N = 8, AW = 32;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_bank = 0, wr_sup_en = 0, wr_usr_en = 0;
  logic [2:0] wr_idx = 0;
  logic [AW-1:0] wr_base = 0, wr_mask = 0, wr_phys = 0, lk_addr = 0;
  logic [1:0] wr_prot = 0;
  logic lk_data = 0, lk_user = 0, lk_write = 0;
  logic hit, can_read, can_write, can_exec;
  logic [AW-1:0] phys_addr;

  always #10 clk = ~clk;

  bat_matcher #(.N(N), .AW(AW)) uut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  logic [AW-1:0] m_base [2][N], m_mask [2][N], m_phys [2][N];
  logic m_sup [2][N], m_usr [2][N];
  logic [1:0] m_prot [2][N];

  function automatic logic [AW+3:0] model(logic [AW-1:0] a, logic d, logic u, logic w);
    for (int i = 0; i < N; i++) begin
      logic en;
      en = u ? m_usr[d][i] : m_sup[d][i];
      if (en && ((a & m_mask[d][i]) == m_base[d][i]) && m_prot[d][i] != 0
          && !(w && m_prot[d][i] == 1))
        return {1'b1, 1'b1, m_prot[d][i][1], 1'b1, m_phys[d][i] | (a & ~m_mask[d][i])};
    end
    return '0;
  endfunction

  task automatic check(string tag, logic [AW+3:0] act, logic [AW+3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put(logic b, int i, logic [AW-1:0] base, logic [AW-1:0] mask,
                     logic [AW-1:0] ph, logic s, logic u, logic [1:0] p);
    @(negedge clk);
    wr_en = 1; wr_bank = b; wr_idx = 3'(i); wr_base = base; wr_mask = mask;
    wr_phys = ph; wr_sup_en = s; wr_usr_en = u; wr_prot = p;
    @(negedge clk);
    wr_en = 0;
    m_base[b][i] = base; m_mask[b][i] = mask; m_phys[b][i] = ph;
    m_sup[b][i] = s; m_usr[b][i] = u; m_prot[b][i] = p;
  endtask

  task automatic look(string tag, logic [AW-1:0] a, logic d, logic u, logic w);
    lk_addr = a; lk_data = d; lk_user = u; lk_write = w;
    #2;
    check(tag, {hit, can_read, can_write, can_exec, phys_addr}, model(a, d, u, w));
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < N; i++) begin
        m_base[b][i] = 0; m_mask[b][i] = 0; m_phys[b][i] = 0;
        m_sup[b][i] = 0; m_usr[b][i] = 0; m_prot[b][i] = 0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9: reset leaves nothing enabled, even with an all-matching address
    look("R9 reset miss", 32'h0, 0, 0, 0);
    look("R8 reset zero data", 32'h1234_5678, 1, 1, 1);

    // R3 R4: one data entry, high nibble region
    put(1, 2, 32'h3000_0000, 32'hF000_0000, 32'h8000_0000, 1, 0, 2);
    look("R4 translate", 32'h3ABC_DEF0, 1, 0, 1);
    look("R3 no match", 32'h4ABC_DEF0, 1, 0, 0);
    // R1: instruction bank stays empty
    look("R1 other bank", 32'h3ABC_DEF0, 0, 0, 0);
    // R2: entry not user-enabled
    look("R2 user filtered", 32'h3000_0010, 1, 1, 0);

    // R6 R7: entry 0 read-only, entry 1 read/write on same region
    put(1, 0, 32'h3000_0000, 32'hF000_0000, 32'h1000_0000, 1, 1, 1);
    look("R7 low index read", 32'h3000_0044, 1, 0, 0);
    look("R6 skip ro on write", 32'h3000_0044, 1, 0, 1);
    look("R5 read-only perms user", 32'h3000_0044, 1, 1, 0);
    look("R6 user write skipped to miss", 32'h3000_0044, 1, 1, 1);
    // R6: code 0 skipped even on read
    put(1, 0, 32'h3000_0000, 32'hF000_0000, 32'h1000_0000, 1, 1, 0);
    look("R6 skip no access", 32'h3000_0044, 1, 0, 0);
    // R5: code 3 read/write
    put(0, 5, 32'h0000_0000, 32'hFFFE_0000, 32'h0042_0000, 1, 1, 3);
    look("R5 prot3 write", 32'h0001_2345, 0, 1, 1);
    look("R1 data unaffected", 32'h0001_2345, 1, 1, 1);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 3) == 0) begin
        logic [AW-1:0] mk;
        int sh;
        sh = 4 * $urandom_range(1, 5);
        mk = ~(32'hFFFF_FFFF >> sh);
        put($urandom_range(0, 1), $urandom_range(0, N - 1), $urandom() & mk, mk,
            $urandom() & mk, $urandom_range(0, 1), $urandom_range(0, 1),
            2'($urandom_range(0, 3)));
      end else begin
        logic d;
        int k;
        logic [AW-1:0] a;
        d = 1'($urandom_range(0, 1));
        k = $urandom_range(0, N - 1);
        a = ($urandom_range(0, 4) == 0) ? $urandom()
            : (m_base[d][k] | ($urandom() & ~m_mask[d][k]));
        look("R2 R3 R4 R5 R6 R7 random", a, d, 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)));
        @(negedge clk);
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule